// File: doc/BRIEF.md
# Framer Error Counter Bank

This block gathers the error events that a line framer's detectors report and counts them. A microprocessor reads the counts through a small register port. There are three 8-bit event counters: framing-word errors, parity errors and remote block errors. There is also a pair of 4-bit disagreement counters that share one address, and a 16-bit line-code-violation (LCV) counter that is read as two bytes. Reading a counter clears it. An event that lands in the same cycle as the clearing read is kept as the first count of the new interval, so no event is lost or counted twice.

Each counter follows its interrupt enable. With the enable low, the counter stops at its maximum, and a further event sets a sticky status bit. With the enable high, the counter wraps to zero, sets its status bit and raises the shared interrupt. The frame-error and LCV counters keep counting while the framer is out of frame. They also emit a one-cycle carry pulse on wrap, so that wider counters can be built outside the block. A separate control input lets these two wrap without raising an interrupt. The other counters hold their value while out of frame and ignore events in E3 mode.

Top module: `ecb_top`

## Requirements
- R1: The register map is address 0 frame-error count, 1 parity count, 2 disagreement nibbles, 3 remote-error count, 4 LCV low byte, 5 LCV high byte, 6 status, 7 reads zero. Each enabled event adds one. A read with `rd_en` high places the addressed value on `rd_data` after the next clock edge, and `rd_data` holds it until the next read. After reset all counts, status, `rd_data`, `irq` and both carry outputs are zero.
- R2: With its interrupt enable low, a counter stops at its maximum: 255 for 8-bit counters, 15 for a nibble, 65535 for the LCV counter. A further event keeps that value and sets the counter's status bit.
- R3: With its interrupt enable high, an event at the maximum wraps the counter to zero and sets its status bit.
- R4: Status and `int_en` bits map as follows: 0 frame error, 1 parity, 2 disagreement (either nibble), 3 remote error, 4 LCV. `irq`, registered, is high when any status bit with its enable set is high. Reading address 6 returns the status in bits 4:0 and clears it. Reading a counter (address 4 or 5 for LCV) clears that counter's status bit. A bit set in the same cycle as a clear stays set.
- R5: A read clears the addressed counter. If an enabled event arrives in the same cycle, the counter becomes 1, and the read returns the value from before that event.
- R6: While `oof` is high, the parity, disagreement and remote-error counters ignore events. The frame-error and LCV counters keep counting.
- R7: While `e3_mode` is high, the parity, disagreement and remote-error counters ignore events. The frame-error and LCV counters keep counting.
- R8: Reading address 4 returns the LCV low byte, clears it and snapshots the high byte. The next read of address 5 returns the snapshot and subtracts it from the live high byte, so carries that arrived in between are kept. A read of address 5 with no snapshot pending returns the live high byte and clears it.
- R9: Address 2 returns the second disagreement nibble in bits 7:4 and the first in bits 3:0. One read clears both.
- R10: `frame_carry` and `lcv_carry` pulse for one cycle after the frame-error or LCV counter wraps to zero.
- R11: With `sat_dis` high, the frame-error and LCV counters wrap instead of saturating. When their interrupt enable is low, the wrap sets no status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Clearing read strobe |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Registered read data |
| ev_frame | input | 1 | Framing-word error event |
| ev_parity | input | 1 | Parity error event |
| ev_dis_a | input | 1 | First disagreement event |
| ev_dis_b | input | 1 | Second disagreement event |
| ev_remote | input | 1 | Remote block error event |
| ev_lcv | input | 1 | Line-code-violation event |
| oof | input | 1 | Out-of-frame indication |
| e3_mode | input | 1 | E3 operating mode |
| int_en | input | 5 | Per-counter interrupt enables |
| sat_dis | input | 1 | Saturation disable for frame-error and LCV counters |
| irq | output | 1 | Shared counter interrupt |
| frame_carry | output | 1 | Frame-error counter carry pulse |
| lcv_carry | output | 1 | LCV counter carry pulse |

## Verification
The assertions check the following on every cycle, using the parity and frame-error counters:
- a saturated counter holds;
- a counter at its maximum wraps to zero and raises `irq`;
- a read clears a counter, or leaves 1 when an event coincides;
- counting is frozen during out-of-frame and E3;
- a carry pulse comes only from a counter at 255;
- `irq` never appears with an empty status register.

Other behaviour is shown only by the bench scenarios, which compare every cycle against a reference model:
- the split LCV read, where a snapshot is followed by a high-byte read across low-byte carries;
- nibble packing and saturation;
- the status read-and-clear race;
- a full 65536-event LCV wrap.

// File: rtl/ecb_pkg.sv
package ecb_pkg;
  localparam int AW = 3;
  localparam int NS = 5;

  localparam logic [AW-1:0] ADR_FRM = 3'd0;
  localparam logic [AW-1:0] ADR_PAR = 3'd1;
  localparam logic [AW-1:0] ADR_DIS = 3'd2;
  localparam logic [AW-1:0] ADR_REM = 3'd3;
  localparam logic [AW-1:0] ADR_LLO = 3'd4;
  localparam logic [AW-1:0] ADR_LHI = 3'd5;
  localparam logic [AW-1:0] ADR_STS = 3'd6;

  localparam int ST_FRM = 0;
  localparam int ST_PAR = 1;
  localparam int ST_DIS = 2;
  localparam int ST_REM = 3;
  localparam int ST_LCV = 4;
endpackage

// File: rtl/ecb_event_ctr.sv
// Clear-on-read event counter: saturates or wraps at its maximum.
module ecb_event_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         clr,
  input  logic         wrap_en,
  output logic [W-1:0] cnt,
  output logic         wrap,
  output logic         sat
);
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] ONE  = W'(1);

  logic at_max;
  assign at_max = (cnt == MAXV);
  assign wrap   = inc && !clr && at_max && wrap_en;
  assign sat    = inc && !clr && at_max && !wrap_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (clr) begin
      // an event in the read cycle opens the new interval
      cnt <= inc ? ONE : '0;
    end else if (inc && !at_max) begin
      cnt <= cnt + ONE;
    end else if (wrap) begin
      cnt <= '0;
    end
  end
endmodule

// File: rtl/ecb_split_ctr.sv
// Wide counter read as a low and a high part, with a high-part snapshot.
module ecb_split_ctr #(
  parameter int LW  = 16,
  parameter int LOW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inc,
  input  logic            rd_lo,
  input  logic            rd_hi,
  input  logic            wrap_en,
  output logic [LOW-1:0]  lo_val,
  output logic [LW-LOW-1:0] hi_val,
  output logic            wrap,
  output logic            sat
);
  localparam int HW = LW - LOW;
  localparam logic [LW-1:0] MAXV = '1;
  localparam logic [LW-1:0] ONE  = LW'(1);

  logic [LW-1:0]  cnt;
  logic [HW-1:0]  snap;
  logic           snap_vld;
  logic [LOW-1:0] lo_base;
  logic [HW-1:0]  hi_base;
  logic [LW-1:0]  base;
  logic [LW-1:0]  nxt;
  logic           at_max;

  always_comb begin
    lo_base = rd_lo ? '0 : cnt[LOW-1:0];
    if (rd_hi) begin
      hi_base = snap_vld ? (cnt[LW-1:LOW] - snap) : '0;
    end else begin
      hi_base = cnt[LW-1:LOW];
    end
    base   = {hi_base, lo_base};
    at_max = (base == MAXV);
    if (!inc) begin
      nxt = base;
    end else if (!at_max) begin
      nxt = base + ONE;
    end else begin
      nxt = wrap_en ? '0 : base;
    end
  end

  assign wrap   = inc && at_max && wrap_en;
  assign sat    = inc && at_max && !wrap_en;
  assign lo_val = cnt[LOW-1:0];
  assign hi_val = snap_vld ? snap : cnt[LW-1:LOW];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      snap     <= '0;
      snap_vld <= 1'b0;
    end else begin
      cnt <= nxt;
      if (rd_lo) begin
        snap     <= cnt[LW-1:LOW];
        snap_vld <= 1'b1;
      end else if (rd_hi) begin
        snap     <= '0;
        snap_vld <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ecb_status.sv
// Sticky per-counter indication register and shared interrupt.
module ecb_status #(
  parameter int NS = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NS-1:0] set,
  input  logic [NS-1:0] clr,
  input  logic [NS-1:0] int_en,
  output logic [NS-1:0] stat,
  output logic          irq
);
  logic [NS-1:0] nxt;
  assign nxt = (stat & ~clr) | set;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= '0;
      irq  <= 1'b0;
    end else begin
      stat <= nxt;
      irq  <= |(nxt & int_en);
    end
  end
endmodule

// File: rtl/ecb_top.sv
// Error counter bank with clear-on-read register access.
module ecb_top
  import ecb_pkg::*;
#(
  parameter int CW = 8,
  parameter int NW = 4,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [CW-1:0] rd_data,
  input  logic          ev_frame,
  input  logic          ev_parity,
  input  logic          ev_dis_a,
  input  logic          ev_dis_b,
  input  logic          ev_remote,
  input  logic          ev_lcv,
  input  logic          oof,
  input  logic          e3_mode,
  input  logic [NS-1:0] int_en,
  input  logic          sat_dis,
  output logic          irq,
  output logic          frame_carry,
  output logic          lcv_carry
);
  localparam int NP = 3;        // plain CW-bit counters: frame, parity, remote
  localparam int NN = 2;        // disagreement nibbles
  localparam int HW = LW - CW;

  logic gate;
  assign gate = !oof && !e3_mode;

  logic hit_frm, hit_par, hit_dis, hit_rem, hit_llo, hit_lhi, hit_sts;
  assign hit_frm = rd_en && (rd_addr == ADR_FRM);
  assign hit_par = rd_en && (rd_addr == ADR_PAR);
  assign hit_dis = rd_en && (rd_addr == ADR_DIS);
  assign hit_rem = rd_en && (rd_addr == ADR_REM);
  assign hit_llo = rd_en && (rd_addr == ADR_LLO);
  assign hit_lhi = rd_en && (rd_addr == ADR_LHI);
  assign hit_sts = rd_en && (rd_addr == ADR_STS);

  // plain counters
  logic [NP-1:0] pc_ev, pc_clr, pc_wen, pc_wrap, pc_sat;
  logic [CW-1:0] pc_cnt [NP];

  assign pc_ev  = {ev_remote && gate, ev_parity && gate, ev_frame};
  assign pc_clr = {hit_rem, hit_par, hit_frm};
  assign pc_wen = {int_en[ST_REM], int_en[ST_PAR], int_en[ST_FRM] || sat_dis};

  for (genvar g = 0; g < NP; g++) begin : g_pc
    ecb_event_ctr #(.W(CW)) u_pc (
      .clk     (clk),
      .rst     (rst),
      .inc     (pc_ev[g]),
      .clr     (pc_clr[g]),
      .wrap_en (pc_wen[g]),
      .cnt     (pc_cnt[g]),
      .wrap    (pc_wrap[g]),
      .sat     (pc_sat[g])
    );
  end

  // disagreement nibbles
  logic [NN-1:0] nb_ev, nb_wrap, nb_sat;
  logic [NW-1:0] nb_cnt [NN];
  assign nb_ev = {ev_dis_b && gate, ev_dis_a && gate};

  for (genvar g = 0; g < NN; g++) begin : g_nb
    ecb_event_ctr #(.W(NW)) u_nb (
      .clk     (clk),
      .rst     (rst),
      .inc     (nb_ev[g]),
      .clr     (hit_dis),
      .wrap_en (int_en[ST_DIS]),
      .cnt     (nb_cnt[g]),
      .wrap    (nb_wrap[g]),
      .sat     (nb_sat[g])
    );
  end

  // line-code-violation counter
  logic [CW-1:0] lcv_lo;
  logic [HW-1:0] lcv_hi;
  logic          lcv_wrap, lcv_sat;

  ecb_split_ctr #(.LW(LW), .LOW(CW)) u_lcv (
    .clk     (clk),
    .rst     (rst),
    .inc     (ev_lcv),
    .rd_lo   (hit_llo),
    .rd_hi   (hit_lhi),
    .wrap_en (int_en[ST_LCV] || sat_dis),
    .lo_val  (lcv_lo),
    .hi_val  (lcv_hi),
    .wrap    (lcv_wrap),
    .sat     (lcv_sat)
  );

  // status
  logic [NS-1:0] st_set, st_clr, stat_q;

  always_comb begin
    st_set         = '0;
    st_set[ST_FRM] = (pc_wrap[0] && int_en[ST_FRM]) || pc_sat[0];
    st_set[ST_PAR] = (pc_wrap[1] && int_en[ST_PAR]) || pc_sat[1];
    st_set[ST_DIS] = ((|nb_wrap) && int_en[ST_DIS]) || (|nb_sat);
    st_set[ST_REM] = (pc_wrap[2] && int_en[ST_REM]) || pc_sat[2];
    st_set[ST_LCV] = (lcv_wrap && int_en[ST_LCV]) || lcv_sat;
    if (hit_sts) begin
      st_clr = '1;
    end else begin
      st_clr         = '0;
      st_clr[ST_FRM] = hit_frm;
      st_clr[ST_PAR] = hit_par;
      st_clr[ST_DIS] = hit_dis;
      st_clr[ST_REM] = hit_rem;
      st_clr[ST_LCV] = hit_llo || hit_lhi;
    end
  end

  ecb_status #(.NS(NS)) u_sts (
    .clk    (clk),
    .rst    (rst),
    .set    (st_set),
    .clr    (st_clr),
    .int_en (int_en),
    .stat   (stat_q),
    .irq    (irq)
  );

  // read path
  logic [CW-1:0] rd_mux;
  always_comb begin
    case (rd_addr)
      ADR_FRM: rd_mux = pc_cnt[0];
      ADR_PAR: rd_mux = pc_cnt[1];
      ADR_DIS: rd_mux = CW'({nb_cnt[1], nb_cnt[0]});
      ADR_REM: rd_mux = pc_cnt[2];
      ADR_LLO: rd_mux = lcv_lo;
      ADR_LHI: rd_mux = CW'(lcv_hi);
      ADR_STS: rd_mux = CW'(stat_q);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data     <= '0;
      frame_carry <= 1'b0;
      lcv_carry   <= 1'b0;
    end else begin
      if (rd_en) rd_data <= rd_mux;
      frame_carry <= pc_wrap[0];
      lcv_carry   <= lcv_wrap;
    end
  end

  // observation points for the bound checker
  logic [CW-1:0] par_q, frm_q;
  assign par_q = pc_cnt[1];
  assign frm_q = pc_cnt[0];
endmodule

// File: rtl/ecb_chk.sv
module ecb_chk #(
  parameter int CW = 8,
  parameter int NS = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_en,
  input logic [2:0]    rd_addr,
  input logic          ev_frame,
  input logic          ev_parity,
  input logic          oof,
  input logic          e3_mode,
  input logic [NS-1:0] int_en,
  input logic          irq,
  input logic          frame_carry,
  input logic [CW-1:0] par_q,
  input logic [CW-1:0] frm_q,
  input logic [NS-1:0] stat_q
);
  localparam logic [CW-1:0] MAXV = '1;

  logic rd_par, rd_frm;
  assign rd_par = rd_en && (rd_addr == 3'd1);
  assign rd_frm = rd_en && (rd_addr == 3'd0);

  p_sat_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!int_en[1] && par_q == MAXV && !rd_par) |=> (par_q == MAXV));

  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (int_en[1] && par_q == MAXV && ev_parity && !oof && !e3_mode && !rd_par)
    |=> (par_q == '0 && irq));

  p_irq_source_r4: assert property (@(posedge clk) disable iff (rst)
    irq |-> (|stat_q));

  p_read_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_par && !ev_parity) |=> (par_q == '0));

  p_read_coincide_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_par && ev_parity && !oof && !e3_mode) |=> (par_q == CW'(1)));

  p_freeze_r6: assert property (@(posedge clk) disable iff (rst)
    ((oof || e3_mode) && !rd_par) |=> $stable(par_q));

  p_frame_counts_oof_r6: assert property (@(posedge clk) disable iff (rst)
    (oof && ev_frame && frm_q != MAXV && !rd_frm) |=> (frm_q == $past(frm_q) + CW'(1)));

  p_carry_src_r10: assert property (@(posedge clk) disable iff (rst)
    frame_carry |-> ($past(frm_q) == MAXV));
endmodule

bind ecb_top ecb_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .rd_en       (rd_en),
  .rd_addr     (rd_addr),
  .ev_frame    (ev_frame),
  .ev_parity   (ev_parity),
  .oof         (oof),
  .e3_mode     (e3_mode),
  .int_en      (int_en),
  .irq         (irq),
  .frame_carry (frame_carry),
  .par_q       (par_q),
  .frm_q       (frm_q),
  .stat_q      (stat_q)
);

// File: tb/tb_ecb_top.sv
module tb_ecb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rd_en = 1'b0;
  logic [2:0] rd_addr = 3'd0;
  logic [7:0] rd_data;
  logic       ev_frame = 0, ev_parity = 0, ev_dis_a = 0, ev_dis_b = 0, ev_remote = 0, ev_lcv = 0;
  logic       oof = 0, e3_mode = 0, sat_dis = 0;
  logic [4:0] int_en = 5'd0;
  logic       irq, frame_carry, lcv_carry;

  always #4 clk = ~clk;

  ecb_top dut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .ev_frame(ev_frame), .ev_parity(ev_parity), .ev_dis_a(ev_dis_a), .ev_dis_b(ev_dis_b),
    .ev_remote(ev_remote), .ev_lcv(ev_lcv), .oof(oof), .e3_mode(e3_mode),
    .int_en(int_en), .sat_dis(sat_dis), .irq(irq), .frame_carry(frame_carry),
    .lcv_carry(lcv_carry)
  );

  int    checks = 0;
  int    failures = 0;
  bit    done = 0;
  string cur_tag = "R1";

  // reference model state
  int       m_c [3];          // frame, parity, remote
  int       m_na, m_nb, m_l, m_snap;
  bit       m_sv;
  bit [4:0] m_st;
  int       exp_rd;
  bit       exp_irq, exp_fc, exp_lc;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void step_c(input int cur, input int maxv, input bit ev, input bit clr,
                                 input bit wen, output int nxt, output bit wr, output bit st);
    wr = 0; st = 0;
    if (clr)              nxt = ev ? 1 : 0;
    else if (!ev)         nxt = cur;
    else if (cur < maxv)  nxt = cur + 1;
    else if (wen) begin   nxt = 0; wr = 1; end
    else begin            nxt = cur; st = 1; end
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 3; i++) m_c[i] = 0;
    m_na = 0; m_nb = 0; m_l = 0; m_snap = 0; m_sv = 0; m_st = 0;
    exp_rd = 0; exp_irq = 0; exp_fc = 0; exp_lc = 0;
  endtask

  task automatic model_step();
    bit g, cf, cp, cd, cr, cl, ch, cs;
    int n0, n1, n2, na, nb, nl, lo, hi, base;
    bit w0, s0, w1, s1, w2, s2, wa, sa, wb, sb, wl, sl;
    bit [4:0] set, clrm;
    g  = !oof && !e3_mode;
    cf = rd_en && rd_addr == 3'd0; cp = rd_en && rd_addr == 3'd1;
    cd = rd_en && rd_addr == 3'd2; cr = rd_en && rd_addr == 3'd3;
    cl = rd_en && rd_addr == 3'd4; ch = rd_en && rd_addr == 3'd5;
    cs = rd_en && rd_addr == 3'd6;
    if (rd_en) begin
      case (rd_addr)
        3'd0: exp_rd = m_c[0];
        3'd1: exp_rd = m_c[1];
        3'd2: exp_rd = m_nb * 16 + m_na;
        3'd3: exp_rd = m_c[2];
        3'd4: exp_rd = m_l % 256;
        3'd5: exp_rd = m_sv ? m_snap : m_l / 256;
        3'd6: exp_rd = int'(m_st);
        default: exp_rd = 0;
      endcase
    end
    step_c(m_c[0], 255, ev_frame, cf, int_en[0] | sat_dis, n0, w0, s0);
    step_c(m_c[1], 255, ev_parity & g, cp, int_en[1], n1, w1, s1);
    step_c(m_c[2], 255, ev_remote & g, cr, int_en[3], n2, w2, s2);
    step_c(m_na, 15, ev_dis_a & g, cd, int_en[2], na, wa, sa);
    step_c(m_nb, 15, ev_dis_b & g, cd, int_en[2], nb, wb, sb);
    lo = cl ? 0 : m_l % 256;
    hi = m_l / 256;
    if (ch) hi = m_sv ? hi - m_snap : 0;
    base = hi * 256 + lo;
    step_c(base, 65535, ev_lcv, 1'b0, int_en[4] | sat_dis, nl, wl, sl);
    if (cl) begin m_snap = m_l / 256; m_sv = 1; end
    else if (ch) begin m_snap = 0; m_sv = 0; end
    set[0] = (w0 & int_en[0]) | s0;
    set[1] = (w1 & int_en[1]) | s1;
    set[2] = ((wa | wb) & int_en[2]) | sa | sb;
    set[3] = (w2 & int_en[3]) | s2;
    set[4] = (wl & int_en[4]) | sl;
    clrm = cs ? 5'h1f : {cl | ch, cr, cd, cp, cf};
    m_st = (m_st & ~clrm) | set;
    exp_irq = |(m_st & int_en);
    exp_fc = w0; exp_lc = wl;
    m_c[0] = n0; m_c[1] = n1; m_c[2] = n2; m_na = na; m_nb = nb; m_l = nl;
  endtask

  task automatic compare();
    chk({cur_tag, " rd_data"}, int'(rd_data), exp_rd);
    chk("R4 irq", int'(irq), int'(exp_irq));
    chk("R10 frame_carry", int'(frame_carry), int'(exp_fc));
    chk("R10 lcv_carry", int'(lcv_carry), int'(exp_lc));
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic rd(input logic [2:0] a);
    rd_en = 1; rd_addr = a;
    tick();
    rd_en = 0;
  endtask

  task automatic set_ev(input bit f, input bit p, input bit da, input bit db, input bit r, input bit l);
    ev_frame = f; ev_parity = p; ev_dis_a = da; ev_dis_b = db; ev_remote = r; ev_lcv = l;
  endtask

  task automatic drain();
    set_ev(0, 0, 0, 0, 0, 0);
    for (int a = 0; a < 7; a++) rd(3'(a));
  endtask

  task automatic rphase(input int n, input int rdiv, input bit o, input bit e);
    oof = o; e3_mode = e;
    for (int i = 0; i < n; i++) begin
      set_ev($urandom_range(1), $urandom_range(1), $urandom_range(1),
             $urandom_range(1), $urandom_range(1), $urandom_range(1));
      rd_en = ($urandom_range(rdiv - 1) == 0);
      rd_addr = 3'($urandom_range(7));
      if ($urandom_range(63) == 0) int_en = 5'($urandom_range(31));
      if ($urandom_range(127) == 0) sat_dis = ~sat_dis;
      tick();
    end
    rd_en = 0; oof = 0; e3_mode = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    cur_tag = "R1";
    compare();

    // R1: mixed traffic with frequent reads
    rphase(400, 4, 0, 0);
    drain();

    // R2: saturation with interrupts off
    cur_tag = "R2"; int_en = 0; sat_dis = 0;
    set_ev(1, 1, 1, 1, 1, 1);
    repeat (300) tick();
    drain();

    // R3: wrap with interrupts on
    cur_tag = "R3"; int_en = 5'h1f;
    set_ev(1, 1, 1, 1, 1, 0);
    repeat (300) tick();
    drain();

    // R4: status reads mixed with dense events
    cur_tag = "R4";
    rphase(1500, 24, 0, 0);
    drain();

    // R5: read coinciding with an event
    cur_tag = "R5"; int_en = 0;
    set_ev(0, 1, 0, 0, 0, 0);
    repeat (5) tick();
    rd(3'd1);
    set_ev(0, 0, 0, 0, 0, 0);
    rd(3'd1);
    rd(3'd1);

    // R6 and R7: gating
    cur_tag = "R6";
    rphase(600, 16, 1, 0);
    drain();
    cur_tag = "R7";
    rphase(600, 16, 0, 1);
    drain();

    // R8: split LCV read across carries
    cur_tag = "R8"; int_en = 0; sat_dis = 0;
    set_ev(0, 0, 0, 0, 0, 1);
    repeat (300) tick();
    rd(3'd4);
    repeat (300) tick();
    rd(3'd5);
    rd(3'd4);
    rd(3'd5);
    rd(3'd5);
    drain();

    // R9: nibble packing and nibble saturation
    cur_tag = "R9";
    set_ev(0, 0, 1, 0, 0, 0);
    repeat (7) tick();
    set_ev(0, 0, 0, 1, 0, 0);
    repeat (3) tick();
    rd(3'd2);
    set_ev(0, 0, 1, 0, 0, 0);
    repeat (20) tick();
    rd(3'd6);
    drain();

    // R11 and R10: saturation disable with carries
    cur_tag = "R11"; int_en = 0; sat_dis = 1;
    set_ev(1, 0, 0, 0, 0, 1);
    repeat (600) tick();
    rd(3'd6);
    repeat (65536) tick();
    rd(3'd6);
    cur_tag = "R10";
    drain();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule